// File: doc/BRIEF.md
# Dual-Mode Serial Converter Frame Controller

This block is the digital front end of a multiplexed sampling converter. A host runs serial frames over a chip select, a frame sync, a serial clock and a data input. The block decides how each frame begins from the frame-sync level seen when chip select drops. With frame sync high, the frame is chip-select framed (SPI style). With frame sync low, the block waits for a frame-sync rising edge (DSP style). During the frame it does three things. It shifts a four-bit command in from the data input. It drives the last conversion result out, MSB first, on a data output that has a separate output enable for the pad. It opens and closes the sample window of the sample-and-hold.

All serial pins are taken as already synchronous to `clk`. Edges are found by comparing each pin with its value one clock earlier.

The frame state machine has three states:
- `FR_IDLE`: no frame.
- `FR_WAIT_FS`: chip select is low and the block waits for frame sync.
- `FR_SHIFT`: the frame runs.

Its transitions are:
- `FR_IDLE`→`FR_SHIFT` on a chip-select fall with frame sync high.
- `FR_IDLE`→`FR_WAIT_FS` on a chip-select fall with frame sync low.
- `FR_WAIT_FS`→`FR_SHIFT` on a frame-sync rise.
- Any state→`FR_IDLE` while chip select is high.

The sample state machine has three states: `SH_IDLE` (hold), `SH_TRACK` (sampling) and `SH_CONV` (a one-cycle conversion-start strobe).

Its transitions are:
- `SH_IDLE`→`SH_TRACK` when the fourth serial-clock rising edge of the frame completes the command.
- `SH_TRACK`→`SH_CONV` when the programmed number of further rising edges has been seen.
- `SH_TRACK`→`SH_IDLE` if the frame ends early.
- `SH_CONV`→`SH_IDLE` always.

Top module: `adc_frame_ctrl`

## Requirements
- R1: After reset, `sdo_oe`, `sample_hold` and `conv_start` are 0, and the sample length is short (12).
- R2: A `cs_n` fall while `fs` is 1 starts the frame at once. `sdo_oe` is 1 from the next cycle on, and serial-clock edges count from that point.
- R3: A `cs_n` fall while `fs` is 0 sets `sdo_oe` but ignores serial-clock edges. The frame, and the clearing of the edge count, begin at the next `fs` rise.
- R4: While `cs_n` is 1, `sdo_oe` is 0 from the next cycle, and serial-clock edges and `sdi` have no effect: no sampling and no configuration change.
- R5: At frame start `conv_result` is captured and its MSB appears on `sdo`. Each `sclk` fall within the frame moves to the next lower bit. After the LSB, `sdo` is 0.
- R6: `sdo` changes only on `sclk` falls, and `sdi` is taken on `sclk` rises. `sample_hold` goes to 1 in the cycle after the fourth `sclk` rise of the frame, and this happens at most once per frame.
- R7: With short length, `sample_hold` returns to 0 and `conv_start` pulses for exactly one cycle after the 16th `sclk` rise of the frame. That is 12 rises after the start.
- R8: With long length, the same happens after the 48th `sclk` rise (44 after the start). This needs a window counter beyond the 4-bit edge counter, which wraps at 16.
- R9: The first four `sdi` bits of the frame form the command, first bit as MSB. `1010` selects short length and `1011` selects long length, effective from the next frame. Every other value is a data read and leaves the length unchanged.
- R10: With `sdi` held at 1, every command is `1111` (read). The block keeps the reset default (short) with no programming frame.
- R11: If `cs_n` rises while `sample_hold` is 1, `sample_hold` drops within one cycle and no `conv_start` is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| fs | input | 1 | Frame sync |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial command input |
| conv_result | input | RES_W | Latest result from the converter core |
| sdo | output | 1 | Serial result output |
| sdo_oe | output | 1 | Output enable for the `sdo` pad |
| sample_hold | output | 1 | 1 = sampling, 0 = hold |
| conv_start | output | 1 | One-cycle conversion-start strobe |

## Verification
The bench builds the block with its defaults: a 12-bit result, a 4-bit command and edge counter, and windows of 12 and 44 edges. Frames of up to 52 serial clocks therefore bring several things within reach:
- the wrap of the 4-bit counter at 16 without a second sample start;
- the 48th-edge window close in long mode;
- the run of zeros after the LSB.

Both framing styles are paired with both window lengths. Early frame ends cut through open windows.

// File: rtl/afc_pkg.sv
package afc_pkg;

    localparam int CMD_W = 4;

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_WAIT_FS,
        FR_SHIFT
    } frame_st_t;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_TRACK,
        SH_CONV
    } samp_st_t;

    localparam logic [CMD_W-1:0] CMD_SET_SHORT = 4'b1010;
    localparam logic [CMD_W-1:0] CMD_SET_LONG  = 4'b1011;

endpackage

// File: rtl/afc_edge.sv
module afc_edge #(
    parameter bit FALLING = 1'b0,
    parameter bit IDLE_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic edge_o
);
    logic prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= IDLE_LVL;
        else        prev <= din;
    end

    generate
        if (FALLING) begin : g_fall
            assign edge_o = prev & ~din;
        end else begin : g_rise
            assign edge_o = ~prev & din;
        end
    endgenerate
endmodule

// File: rtl/afc_frame_fsm.sv
module afc_frame_fsm
    import afc_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic fs,
    input  logic cs_fall,
    input  logic fs_rise,
    input  logic sclk_rise,
    input  logic sdi,
    output logic frame_on,
    output logic shifting,
    output logic start,
    output logic bit_act,
    output logic go,
    output logic cfg_long
);
    frame_st_t state, state_nx;
    logic [CNT_W-1:0] bit_cnt;
    logic [CMD_W-2:0] cmd_sr;
    logic             nib_done;
    logic [CMD_W-1:0] nibble;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FR_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            FR_IDLE:    if (cs_fall) state_nx = fs ? FR_SHIFT : FR_WAIT_FS;
            FR_WAIT_FS: if (cs_n) state_nx = FR_IDLE;
                        else if (fs_rise) state_nx = FR_SHIFT;
            FR_SHIFT:   if (cs_n) state_nx = FR_IDLE;
            default:    state_nx = FR_IDLE;
        endcase
    end

    always_comb begin
        frame_on = (state != FR_IDLE);
        shifting = (state == FR_SHIFT);
        start    = ((state == FR_IDLE) && cs_fall)
                 || ((state == FR_WAIT_FS) && fs_rise && !cs_n);
        bit_act  = shifting && !cs_n && sclk_rise;
        nibble   = {cmd_sr, sdi};
        go       = bit_act && !nib_done && (bit_cnt == CNT_W'(CMD_W - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            cmd_sr   <= '0;
            nib_done <= 1'b0;
            cfg_long <= 1'b0;
        end else if (start) begin
            bit_cnt  <= '0;
            nib_done <= 1'b0;
        end else if (bit_act) begin
            bit_cnt <= bit_cnt + 1'b1;
            cmd_sr  <= nibble[CMD_W-2:0];
            if (go) begin
                nib_done <= 1'b1;
                if (nibble == CMD_SET_SHORT)     cfg_long <= 1'b0;
                else if (nibble == CMD_SET_LONG) cfg_long <= 1'b1;
            end
        end
    end

    // R4
    cs_high_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (state == FR_IDLE));
    // R3
    wait_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FR_WAIT_FS) |=> (bit_cnt == '0));
    // R9
    cfg_on_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_long) |-> $past(go));
endmodule

// File: rtl/afc_sample_fsm.sv
module afc_sample_fsm
    import afc_pkg::*;
#(
    parameter int SHORT_LEN = 12,
    parameter int LONG_LEN  = 44
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic long_sel,
    input  logic bit_act,
    input  logic frame_on,
    output logic sample_hold,
    output logic conv_start
);
    localparam int WIN_W = $clog2(LONG_LEN + 1);

    samp_st_t         state, state_nx;
    logic [WIN_W-1:0] win_cnt;
    logic             long_q;
    logic [WIN_W-1:0] lim;

    assign lim = long_q ? WIN_W'(LONG_LEN) : WIN_W'(SHORT_LEN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SH_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SH_IDLE:  if (go) state_nx = SH_TRACK;
            SH_TRACK: if (!frame_on) state_nx = SH_IDLE;
                      else if (bit_act && (win_cnt == lim - 1'b1)) state_nx = SH_CONV;
            SH_CONV:  state_nx = SH_IDLE;
            default:  state_nx = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_cnt <= '0;
            long_q  <= 1'b0;
        end else if (go) begin
            win_cnt <= '0;
            long_q  <= long_sel;
        end else if ((state == SH_TRACK) && bit_act) begin
            win_cnt <= win_cnt + 1'b1;
        end
    end

    always_comb begin
        sample_hold = (state == SH_TRACK);
        conv_start  = (state == SH_CONV);
    end

    // R7
    conv_after_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> $past(sample_hold));
    // R8
    win_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_hold |-> (win_cnt < lim));
    // R11
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_hold && !frame_on) |=> (!sample_hold && !conv_start));
    // R6
    track_needs_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sample_hold) |-> $past(go));
endmodule

// File: rtl/afc_sdo_shift.sv
module afc_sdo_shift #(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             shift,
    input  logic [RES_W-1:0] din,
    output logic             sdo
);
    logic [RES_W-1:0] sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sr <= '0;
        else if (load)  sr <= din;
        else if (shift) sr <= {sr[RES_W-2:0], 1'b0};
    end

    assign sdo = sr[RES_W-1];

    // R5
    load_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (sdo == $past(din[RES_W-1])));
endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl #(
    parameter int RES_W     = 12,
    parameter int CNT_W     = 4,
    parameter int SHORT_LEN = 12,
    parameter int LONG_LEN  = 44
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             fs,
    input  logic             sclk,
    input  logic             sdi,
    input  logic [RES_W-1:0] conv_result,
    output logic             sdo,
    output logic             sdo_oe,
    output logic             sample_hold,
    output logic             conv_start
);
    logic cs_fall, fs_rise, sclk_rise, sclk_fall;
    logic frame_on, shifting, start, bit_act, go, cfg_long;

    afc_edge #(.FALLING(1'b1), .IDLE_LVL(1'b1)) u_cs_edge (
        .clk(clk), .rst_n(rst_n), .din(cs_n), .edge_o(cs_fall));
    afc_edge #(.FALLING(1'b0), .IDLE_LVL(1'b1)) u_fs_edge (
        .clk(clk), .rst_n(rst_n), .din(fs), .edge_o(fs_rise));
    afc_edge #(.FALLING(1'b0), .IDLE_LVL(1'b1)) u_sclk_rise (
        .clk(clk), .rst_n(rst_n), .din(sclk), .edge_o(sclk_rise));
    afc_edge #(.FALLING(1'b1), .IDLE_LVL(1'b0)) u_sclk_fall (
        .clk(clk), .rst_n(rst_n), .din(sclk), .edge_o(sclk_fall));

    afc_frame_fsm #(.CNT_W(CNT_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .fs(fs),
        .cs_fall(cs_fall), .fs_rise(fs_rise), .sclk_rise(sclk_rise), .sdi(sdi),
        .frame_on(frame_on), .shifting(shifting), .start(start),
        .bit_act(bit_act), .go(go), .cfg_long(cfg_long));

    afc_sample_fsm #(.SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)) u_sample (
        .clk(clk), .rst_n(rst_n), .go(go), .long_sel(cfg_long),
        .bit_act(bit_act), .frame_on(frame_on),
        .sample_hold(sample_hold), .conv_start(conv_start));

    afc_sdo_shift #(.RES_W(RES_W)) u_sdo (
        .clk(clk), .rst_n(rst_n), .load(start),
        .shift(shifting && !cs_n && sclk_fall),
        .din(conv_result), .sdo(sdo));

    assign sdo_oe = frame_on;

    // R2
    oe_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> sdo_oe);
endmodule

// File: tb/adc_frame_ctrl_bench.sv
module adc_frame_ctrl_bench;
    localparam int RES_W = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, fs = 1'b1, sclk = 1'b0, sdi = 1'b1;
    logic [RES_W-1:0] conv_result;
    logic sdo, sdo_oe, sample_hold, conv_start;

    int  checks = 0;
    int  errors = 0;
    bit  cfg_long_m = 1'b0;

    always #4 clk = ~clk;

    adc_frame_ctrl u_adc_frame_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .fs(fs), .sclk(sclk), .sdi(sdi),
        .conv_result(conv_result), .sdo(sdo), .sdo_oe(sdo_oe),
        .sample_hold(sample_hold), .conv_start(conv_start));

    // converter core stub: new result after each conversion strobe
    always @(posedge clk) begin
        if (!rst_n)          conv_result <= 12'hA5C;
        else if (conv_start) conv_result <= 12'($urandom);
    end

    function automatic bit exp_hold(input int i, input int len);
        return (i >= 4) && (i < 4 + len);
    endfunction

    function automatic bit exp_sdo(input logic [RES_W-1:0] r, input int falls);
        return (falls < RES_W) ? r[RES_W-1-falls] : 1'b0;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic sclk_cycle(output logic h, output logic c, output logic d);
        @(negedge clk) sclk = 1'b1;
        @(negedge clk) begin h = sample_hold; c = conv_start; end
        @(negedge clk);
        @(negedge clk) sclk = 1'b0;
        @(negedge clk) d = sdo;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run_frame(input bit dsp, input logic [3:0] cmd, input int nclk);
        logic [RES_W-1:0] res;
        logic h, c, d;
        int len;
        string hreq;
        len = cfg_long_m ? 44 : 12;
        @(negedge clk) begin fs = dsp ? 1'b0 : 1'b1; sdi = 1'b0; end
        @(negedge clk) cs_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(dsp ? "R3" : "R2", "sdo_oe after cs fall", sdo_oe, 1);
        if (dsp) begin
            for (int p = 0; p < 3; p++) sclk_cycle(h, c, d);
            chk("R3", "hold before fs", h, 0);
            @(negedge clk) fs = 1'b1;
            @(negedge clk);
            @(negedge clk) fs = 1'b0;
        end
        res = conv_result;
        chk("R5", "sdo MSB at start", sdo, res[RES_W-1]);
        for (int i = 1; i <= nclk; i++) begin
            sdi = (i <= 4) ? cmd[4-i] : 1'($urandom);
            sclk_cycle(h, c, d);
            hreq = (i <= 4) ? "R6" : (len == 44 ? "R8" : "R7");
            chk(hreq, $sformatf("sample_hold rise %0d", i), h, exp_hold(i, len));
            chk(len == 44 ? "R8" : "R7", $sformatf("conv_start rise %0d", i),
                c, (i == 4 + len));
            chk("R5", $sformatf("sdo fall %0d", i), d, exp_sdo(res, i));
        end
        @(negedge clk) cs_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R4", "sdo_oe after cs rise", sdo_oe, 0);
        chk("R11", "hold after frame end", sample_hold, 0);
        chk("R11", "no strobe after frame end", conv_start, 0);
        if (nclk >= 4) begin
            if (cmd == 4'b1010) cfg_long_m = 1'b0;
            else if (cmd == 4'b1011) cfg_long_m = 1'b1;
        end
    endtask

    task automatic idle_sclk(input int n);
        logic h, c, d;
        for (int k = 0; k < n; k++) begin
            sdi = (k % 4 == 1) ? 1'b0 : 1'b1;
            sclk_cycle(h, c, d);
            chk("R4", "hold with cs high", h, 0);
            chk("R4", "sdo_oe with cs high", sdo_oe, 0);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [3:0] cmd;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "sdo_oe reset", sdo_oe, 0);
        chk("R1", "sample_hold reset", sample_hold, 0);
        chk("R1", "conv_start reset", conv_start, 0);

        // R10: sdi tied high, default short window, SPI style
        run_frame(1'b0, 4'b1111, 20);
        // R9: program long, current frame still short
        run_frame(1'b0, 4'b1011, 20);
        // R8: SPI long, read command keeps config
        run_frame(1'b0, 4'b0000, 52);
        // R3: DSP long, program short
        run_frame(1'b1, 4'b1010, 50);
        // DSP short
        run_frame(1'b1, 4'b1111, 20);
        // R4: clocks with cs high carrying a long-select pattern are ignored
        idle_sclk(12);
        run_frame(1'b0, 4'b1111, 18);
        // R11: abort in the middle of the window
        run_frame(1'b0, 4'b1011, 10);
        run_frame(1'b0, 4'b1111, 50);

        for (int f = 0; f < 24; f++) begin
            case ($urandom % 4)
                0:       cmd = 4'b1010;
                1:       cmd = 4'b1011;
                default: cmd = 4'($urandom);
            endcase
            run_frame(1'($urandom), cmd, 2 + int'($urandom % 51));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule